// File: doc/BRIEF.md
# Polled Cell Receive Port

This block is the receiving end of a multi-device cell bus where the routing address travels on its own 5-bit address input, separate from the data path. An upstream sender finds out which destinations can take a cell by polling. It places an address on the address pins with the enable low. One clock later, the port answers on a shared cell-available line, but only when that address belongs to it. The line is modelled as a value plus an output-enable, so the port releases it for any address it does not own.

To send a cell, the sender presents the chosen address a second time with the enable high. That commits the selection, provided the destination still has room. From then on, each cycle with the enable high carries one data word, and a fixed-length cell follows. The port drives a start-of-cell indication onto the bus while it waits for the first word. It forwards every word to the selected downstream buffer as a one-hot write strobe, together with the data and a first-word flag. Downstream buffers report "room for a whole cell" on one input bit per destination.

Which addresses the port owns is set by a base address and a destination count. Address 31 is reserved as the null address and never matches anything. While a cell is in progress, the address pins are not looked at.

Top module: `cellrx_port`

## Requirements
- R1: While reset is held, and after it is released, cav_oe, soc_oe and every wr_o bit are 0, and no write is issued until a cell has been selected.
- R2: A poll (bus_en low, port idle) on an owned address A, BASE_ADDR <= A < BASE_ADDR+NUM_DEST, sets cav_oe to 1 on the next clock. On that clock cav_o equals room_i[A-BASE_ADDR].
- R3: A poll on an address outside the owned range, or on the null address 5'h1F, leaves cav_oe at 0 on the next clock.
- R4: With the port idle, bus_en high on an owned address whose room bit is 1 selects that destination. After that clock edge, soc_oe = 1 and soc_o = 1, and the selection cycle itself produces no write.
- R5: With the port idle, bus_en high on an address that is not owned, is null, or whose room bit is 0 selects nothing, and soc_oe stays 0.
- R6: During a transfer, each cycle with bus_en high is one data word. On the next clock, wr_o has exactly the bit of the selected destination set, wdata_o carries that word, and words arrive in order.
- R7: wsoc_o is 1 only with the first word of a cell. soc_o falls to 0 once that first word has been taken.
- R8: A cycle with bus_en low during a transfer writes nothing and does not advance the word count. The selection is kept.
- R9: After exactly CELL_WORDS (default 53) enabled words, the port returns to idle: soc_oe goes to 0 and polls are answered again. During the transfer, the address pins are ignored, cav_oe stays 0, and no new selection is made.
- R10: The cycle right after a cell completes may select again, so cells can follow each other with only the one selection cycle between them.
- R11: Whenever cav_oe is 0, cav_o is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 5 | Destination address from the sender |
| bus_en | input | 1 | Enable, active high: selects on an address when idle, marks valid data during a cell |
| bus_data | input | DATA_W | Cell data word |
| room_i | input | NUM_DEST | Per destination: the buffer can take a complete cell |
| cav_o | output | 1 | Cell-available answer to a poll |
| cav_oe | output | 1 | Output-enable for cav_o |
| soc_o | output | 1 | Start-of-cell indication, high while the first word is awaited |
| soc_oe | output | 1 | Output-enable for soc_o, high while a cell is in progress |
| wr_o | output | NUM_DEST | One-hot write strobe per destination buffer |
| wdata_o | output | DATA_W | Data word for the buffers |
| wsoc_o | output | 1 | First-word flag accompanying the write |

## Verification
Each output comes out of registers, so its delay can be fixed exactly:
- The poll answer on cav_o/cav_oe appears one clock after the address edge.
- soc_oe/soc_o change right after the edge that selects a destination or takes the last word.
- A write strobe with its data appears one clock after the enabled word.

The sequential checks sample outputs 2 ns after the rising edge that follows each stimulus. Write results are handled differently. The driver records each enabled word in an expected queue as it presents it. A monitor at every falling edge compares any strobe against the head of that queue, so stall cycles and ordering are covered without counting cycles by hand.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_CELL = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/rx_reset_sync.sv
module rx_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rx_addr_decode.sv
module rx_addr_decode
  import cellrx_pkg::*;
#(
  parameter int NUM_DEST  = 4,
  parameter int BASE_ADDR = 4,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_DEST-1:0] room_i,
  output logic                hit_o,
  output logic                room_hit_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [NUM_DEST-1:0] hit_vec;

  // One comparator per owned destination slot.
  for (genvar g = 0; g < NUM_DEST; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(BASE_ADDR + g);
    assign hit_vec[g] = (addr_i == SLOT) && (addr_i != NULL_ADDR);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_DEST; i++) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o      = |hit_vec;
  assign room_hit_o = |(hit_vec & room_i);
endmodule

// File: rtl/rx_cell_track.sv
module rx_cell_track
  import cellrx_pkg::*;
#(
  parameter int CELL_WORDS = 53,
  parameter int IDX_W      = 2,
  parameter int CNT_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             word_en_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] sel_idx_o,
  output logic [CNT_W-1:0] word_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(CELL_WORDS - 1);

  xfer_state_e      state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] sel_q, sel_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sel_n   = sel_q;
    case (state_q)
      XS_IDLE: begin
        if (start_i) begin
          state_n = XS_CELL;
          cnt_n   = '0;
          sel_n   = start_idx_i;
        end
      end
      XS_CELL: begin
        if (word_en_i) begin
          if (cnt_q == LAST_WORD) begin
            state_n = XS_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sel_q   <= sel_n;
    end
  end

  assign busy_o     = (state_q == XS_CELL);
  assign sel_idx_o  = sel_q;
  assign word_cnt_o = cnt_q;

  // R4
  start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_IDLE && start_i) |=> (state_q == XS_CELL && cnt_q == '0));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_CELL && !word_en_i) |=>
      (state_q == XS_CELL && $stable(cnt_q) && $stable(sel_q)));
  // R9
  cell_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_CELL && word_en_i && cnt_q == LAST_WORD) |=> (state_q == XS_IDLE));
  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_CELL) |-> (cnt_q <= LAST_WORD));
endmodule

// File: rtl/rx_poll_resp.sv
module rx_poll_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic en_i,
  input  logic hit_i,
  input  logic room_hit_i,
  output logic cav_o,
  output logic cav_oe_o
);
  logic cav_q, cav_n;
  logic oe_q, oe_n;

  always_comb begin
    oe_n  = !busy_i && !en_i && hit_i;
    cav_n = oe_n && room_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cav_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      cav_q <= cav_n;
      oe_q  <= oe_n;
    end
  end

  assign cav_o    = cav_q;
  assign cav_oe_o = oe_q;

  // R11
  cav_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !cav_q);
endmodule

// File: rtl/rx_word_out.sv
module rx_word_out #(
  parameter int NUM_DEST = 4,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_i,
  input  logic                en_i,
  input  logic [IDX_W-1:0]    sel_idx_i,
  input  logic [CNT_W-1:0]    word_cnt_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [NUM_DEST-1:0] wr_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                wsoc_o
);
  logic                take;
  logic [NUM_DEST-1:0] wr_q, wr_n;
  logic                sof_q, sof_n;
  logic [DATA_W-1:0]   data_q;

  assign take = busy_i && en_i;

  always_comb begin
    wr_n = '0;
    if (take) wr_n[sel_idx_i] = 1'b1;
    sof_n = take && (word_cnt_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      sof_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      sof_q <= sof_n;
    end
  end

  // Data path register: loaded only on an accepted word.
  always_ff @(posedge clk) begin
    if (take) data_q <= data_i;
  end

  assign wr_o    = wr_q;
  assign wdata_o = data_q;
  assign wsoc_o  = sof_q;

  // R6
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_q));
  // R6
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && en_i) |=> (|wr_q));
  // R7
  sof_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> (|wr_q));
endmodule

// File: rtl/cellrx_port.sv
module cellrx_port
  import cellrx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_DEST   = 4,
  parameter int BASE_ADDR  = 4,
  parameter int CELL_WORDS = 53
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          bus_addr,
  input  logic                bus_en,
  input  logic [DATA_W-1:0]   bus_data,
  input  logic [NUM_DEST-1:0] room_i,
  output logic                cav_o,
  output logic                cav_oe,
  output logic                soc_o,
  output logic                soc_oe,
  output logic [NUM_DEST-1:0] wr_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                wsoc_o
);
  localparam int IDX_W = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1;
  localparam int CNT_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;

  logic             rst_i_n;
  logic             hit, room_hit, start;
  logic [IDX_W-1:0] hit_idx, sel_idx;
  logic             busy;
  logic [CNT_W-1:0] word_cnt;

  rx_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rx_addr_decode #(
    .NUM_DEST  (NUM_DEST),
    .BASE_ADDR (BASE_ADDR),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr_i     (bus_addr),
    .room_i     (room_i),
    .hit_o      (hit),
    .room_hit_o (room_hit),
    .idx_o      (hit_idx)
  );

  // A selection needs an idle port, the enable, an owned address and room.
  assign start = !busy && bus_en && hit && room_hit;

  rx_cell_track #(
    .CELL_WORDS (CELL_WORDS),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .start_i     (start),
    .start_idx_i (hit_idx),
    .word_en_i   (bus_en),
    .busy_o      (busy),
    .sel_idx_o   (sel_idx),
    .word_cnt_o  (word_cnt)
  );

  rx_poll_resp u_poll (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .busy_i     (busy),
    .en_i       (bus_en),
    .hit_i      (hit),
    .room_hit_i (room_hit),
    .cav_o      (cav_o),
    .cav_oe_o   (cav_oe)
  );

  rx_word_out #(
    .NUM_DEST (NUM_DEST),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .busy_i     (busy),
    .en_i       (bus_en),
    .sel_idx_i  (sel_idx),
    .word_cnt_i (word_cnt),
    .data_i     (bus_data),
    .wr_o       (wr_o),
    .wdata_o    (wdata_o),
    .wsoc_o     (wsoc_o)
  );

  assign soc_oe = busy;
  assign soc_o  = busy && (word_cnt == '0);

  // R5
  reject_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && bus_en && !(hit && room_hit)) |=> !soc_oe);
  // R3
  null_addr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && bus_addr == NULL_ADDR) |=> !cav_oe);
  // R9
  busy_mute_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> !cav_oe);
  // R1
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && !$past(busy)) |-> (wr_o == '0));
endmodule

// File: tb/cellrx_port_test.sv
`timescale 1ns/1ps
module cellrx_port_test;
  localparam int DW = 8;
  localparam int ND = 4;
  localparam int CW = 53;

  typedef struct packed {
    logic [1:0]    dst;
    logic [DW-1:0] d;
    logic          s;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [4:0]    bus_addr;
  logic          bus_en;
  logic [DW-1:0] bus_data;
  logic [ND-1:0] room_i;
  logic          cav_o, cav_oe, soc_o, soc_oe, wsoc_o;
  logic [ND-1:0] wr_o;
  logic [DW-1:0] wdata_o;

  int   total = 0;
  int   bad   = 0;
  exp_t q[$];

  cellrx_port #(.DATA_W(DW), .NUM_DEST(ND), .BASE_ADDR(4), .CELL_WORDS(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_en(bus_en),
    .bus_data(bus_data), .room_i(room_i), .cav_o(cav_o), .cav_oe(cav_oe),
    .soc_o(soc_o), .soc_oe(soc_oe), .wr_o(wr_o), .wdata_o(wdata_o), .wsoc_o(wsoc_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic e, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_en   = e;
    bus_data = d;
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic send_word(input int dst, input logic [DW-1:0] d, input bit first,
                           input logic [4:0] junk_addr);
    exp_t it;
    drive(junk_addr, 1'b1, d);
    it.dst = 2'(dst);
    it.d   = d;
    it.s   = first;
    q.push_back(it);
  endtask

  // Monitor: compare every write strobe against the expected queue.
  always @(negedge clk) begin
    if (|wr_o) begin
      if (q.size() == 0) begin
        chk("R6", "unexpected write", int'(wr_o), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R6", "strobe", int'(wr_o), int'(ND'(1) << e.dst));
        chk("R6", "data", int'(wdata_o), int'(e.d));
        chk("R7", "first-word flag", int'(wsoc_o), int'(e.s));
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL R9 watchdog expired: actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    bus_addr = 5'h1F;
    bus_en   = 1'b0;
    bus_data = '0;
    room_i   = 4'b0101;
    repeat (3) @(posedge clk);
    #2;
    // R1 outputs quiet in reset
    chk("R1", "cav_oe in reset", int'(cav_oe), 0);
    chk("R1", "soc_oe in reset", int'(soc_oe), 0);
    chk("R1", "wr_o in reset", int'(wr_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "soc_oe after reset", int'(soc_oe), 0);

    // R2 polls on owned addresses
    drive(5'd4, 1'b0, '0); settle();
    chk("R2", "cav_oe addr4", int'(cav_oe), 1);
    chk("R2", "cav addr4 room", int'(cav_o), 1);
    drive(5'd5, 1'b0, '0); settle();
    chk("R2", "cav_oe addr5", int'(cav_oe), 1);
    chk("R2", "cav addr5 no room", int'(cav_o), 0);
    // R3 polls on foreign and null addresses
    drive(5'd3, 1'b0, '0); settle();
    chk("R3", "cav_oe addr3", int'(cav_oe), 0);
    chk("R11", "cav quiet addr3", int'(cav_o), 0);
    drive(5'd8, 1'b0, '0); settle();
    chk("R3", "cav_oe addr8", int'(cav_oe), 0);
    drive(5'h1F, 1'b0, '0); settle();
    chk("R3", "cav_oe null", int'(cav_oe), 0);

    // R5 rejected selections
    drive(5'd5, 1'b1, '0); settle();
    chk("R5", "select without room", int'(soc_oe), 0);
    drive(5'd9, 1'b1, '0); settle();
    chk("R5", "select foreign", int'(soc_oe), 0);
    drive(5'h1F, 1'b1, '0); settle();
    chk("R5", "select null", int'(soc_oe), 0);

    // R4 select destination 2 (address 6)
    drive(5'd6, 1'b1, '0); settle();
    chk("R4", "soc_oe after select", int'(soc_oe), 1);
    chk("R4", "soc_o after select", int'(soc_o), 1);
    chk("R4", "no write on select", int'(wr_o), 0);
    chk("R9", "cav_oe during cell", int'(cav_oe), 0);

    for (int i = 0; i < CW; i++) begin
      if (i % 9 == 4) begin
        drive(5'd4, 1'b0, 8'hEE); settle();
        chk("R8", "no write on stall", int'(wr_o), 0);
        chk("R8", "cell kept on stall", int'(soc_oe), 1);
        chk("R9", "poll ignored in cell", int'(cav_oe), 0);
      end
      send_word(2, 8'(i * 3 + 1), (i == 0), (i % 2 == 1) ? 5'd4 : 5'd5);
      if (i == 0) begin
        settle();
        chk("R7", "soc_o after first word", int'(soc_o), 0);
      end
    end
    settle();
    chk("R9", "idle after last word", int'(soc_oe), 0);
    drive(5'd4, 1'b0, '0); settle();
    chk("R9", "poll answered after cell", int'(cav_oe), 1);

    // Cell to destination 0, no stalls
    drive(5'd4, 1'b1, '0); settle();
    chk("R4", "select addr4", int'(soc_oe), 1);
    for (int i = 0; i < CW; i++) begin
      send_word(0, 8'(255 - i), (i == 0), 5'd6);
    end
    // R10 reselect in the very next cycle
    drive(5'd6, 1'b1, '0); settle();
    chk("R10", "back-to-back select", int'(soc_oe), 1);
    chk("R10", "back-to-back soc", int'(soc_o), 1);
    for (int i = 0; i < CW; i++) begin
      send_word(2, 8'(i ^ 8'h5A), (i == 0), 5'd4);
    end
    drive(5'd6, 1'b0, '0);
    room_i = 4'b0000;
    settle();
    chk("R9", "idle after third cell", int'(soc_oe), 0);
    drive(5'd6, 1'b0, '0); settle();
    chk("R2", "cav_oe addr6", int'(cav_oe), 1);
    chk("R2", "cav addr6 full", int'(cav_o), 0);

    repeat (4) @(posedge clk);
    #2;
    chk("R6", "all writes seen", q.size(), 0);
    summary();
    $finish;
  end
endmodule